// File: doc/BRIEF.md
# Parameter-Filtered RAM Initialization Writer

This block sits between an initialization bus decoder and a RAM write port. The decoder presents one word at a time. Each word comes with a parameter identifier, a frame address, an in-frame data index, a valid qualifier and a bus reset. The block drops every word whose identifier differs from a configured constant. For each matching valid word it drives a write address, write data and a write enable toward the RAM. The bus reset is copied to a reset output.

The write address joins the low bits of the frame address (upper part) with the low bits of the data index (lower part). The index supplies log2 of the words-per-frame count. A host loads a whole table by sending frames at consecutive frame addresses, with indices 0 upward inside each frame. Frames × words per frame should equal the RAM depth. The path from the bus to the RAM port is purely combinational. The RAM samples the port on its own clock.

Top module: `init_ram_writer`

## Requirements
- R1: `ramWe` is high exactly when `busValid` is high, `busRst` is low and `busParamId` equals `FILTER_ID`.
- R2: A word whose `busParamId` differs from `FILTER_ID` never raises `ramWe`, so the RAM content at its address is left unchanged.
- R3: `ramData` equals bits `[DATA_W-1:0]` of `busData`. Higher bus bits are discarded. DATA_W may be 1 to 32.
- R4: Bits `[IDX_BITS-1:0]` of `ramAddr` equal bits `[IDX_BITS-1:0]` of `busIndex`, where IDX_BITS = log2(WORDS_PER_FRAME) and WORDS_PER_FRAME is a power of two no larger than 2^ADDR_W.
- R5: Bits `[ADDR_W-1:IDX_BITS]` of `ramAddr` equal bits `[ADDR_W-IDX_BITS-1:0]` of `busFrameAddr`. Higher frame address bits are ignored.
- R6: `ramRst` always equals `busRst`.
- R7: While `busRst` is high, `ramWe` is low whatever the other inputs are.
- R8: Outputs follow inputs with no register stage, within the same clock cycle.
- R9: Sending frames at frame addresses 0, 1, 2, … with indices 0 to WORDS_PER_FRAME-1 fills all 2^ADDR_W RAM entries. Each word lands at frame×WORDS_PER_FRAME + index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busRst | input | 1 | Reset carried on the initialization bus |
| busValid | input | 1 | Qualifies the current bus word |
| busParamId | input | PID_W | Parameter identifier of the current frame |
| busFrameAddr | input | FADDR_W | Frame address field |
| busIndex | input | IDX_W | Data index of the word inside its frame |
| busData | input | 32 | Data word from the bus |
| ramAddr | output | ADDR_W | RAM write address |
| ramData | output | DATA_W | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRst | output | 1 | Reset forwarded from the bus |

## Verification
The block holds no state, so a wrong internal strobe or slice shows at the ports in the same cycle as the word that causes it. The one lasting effect is a corrupted RAM entry, written at the next RAM clock edge. A broken identifier compare or a missing reset gate leaves a foreign word in the behavioural memory. A wrong address slice sends words to the wrong entry or leaves holes. The bench therefore checks the ports directly for each word and reads back the full memory after a complete load interleaved with foreign frames.

// File: rtl/init_ram_writer_pkg.sv
package init_ram_writer_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic idMatch;   // identifier equals the filter constant
    logic writeGo;   // qualified write for this word
    logic rstFwd;    // bus reset to forward
  } wr_ctrl_t;

endpackage

// File: rtl/init_ram_writer_ctrl.sv
module init_ram_writer_ctrl
  import init_ram_writer_pkg::*;
#(
  parameter int PID_W = 8,
  parameter logic [PID_W-1:0] FILTER_ID = 8'h5A
) (
  input  logic             busRst,
  input  logic             busValid,
  input  logic [PID_W-1:0] busParamId,
  output wr_ctrl_t         ctrl
);

  always_comb begin
    ctrl.idMatch = (busParamId == FILTER_ID);
    ctrl.rstFwd  = busRst;
    ctrl.writeGo = busValid & ctrl.idMatch & ~busRst;
  end

endmodule

// File: rtl/init_ram_writer_dp.sv
module init_ram_writer_dp
  import init_ram_writer_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int WORDS_PER_FRAME = 4,
  parameter int FADDR_W = 16,
  parameter int IDX_W   = 8,
  parameter int BUS_W   = 32
) (
  input  wr_ctrl_t           ctrl,
  input  logic [FADDR_W-1:0] busFrameAddr,
  input  logic [IDX_W-1:0]   busIndex,
  input  logic [BUS_W-1:0]   busData,
  output logic [ADDR_W-1:0]  ramAddr,
  output logic [DATA_W-1:0]  ramData,
  output logic               ramWe,
  output logic               ramRst
);

  localparam int IDX_BITS = $clog2(WORDS_PER_FRAME);
  localparam int HI_BITS  = ADDR_W - IDX_BITS;

  // Bits above the used slices are intentionally dropped
  logic unusedSink;
  assign unusedSink = ^{busFrameAddr, busIndex, busData, ctrl.idMatch};

  generate
    if (IDX_BITS == 0) begin : g_no_index
      assign ramAddr = busFrameAddr[ADDR_W-1:0];
    end else if (HI_BITS == 0) begin : g_index_only
      assign ramAddr = busIndex[ADDR_W-1:0];
    end else begin : g_joined
      assign ramAddr = {busFrameAddr[HI_BITS-1:0], busIndex[IDX_BITS-1:0]};
    end
  endgenerate

  assign ramData = busData[DATA_W-1:0];
  assign ramWe   = ctrl.writeGo;
  assign ramRst  = ctrl.rstFwd;

endmodule

// File: rtl/init_ram_writer.sv
module init_ram_writer
  import init_ram_writer_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int WORDS_PER_FRAME = 4,
  parameter int PID_W   = 8,
  parameter logic [PID_W-1:0] FILTER_ID = 8'h5A,
  parameter int FADDR_W = 16,
  parameter int IDX_W   = 8
) (
  input  logic               busRst,
  input  logic               busValid,
  input  logic [PID_W-1:0]   busParamId,
  input  logic [FADDR_W-1:0] busFrameAddr,
  input  logic [IDX_W-1:0]   busIndex,
  input  logic [31:0]        busData,
  output logic [ADDR_W-1:0]  ramAddr,
  output logic [DATA_W-1:0]  ramData,
  output logic               ramWe,
  output logic               ramRst
);

  wr_ctrl_t ctrl;

  init_ram_writer_ctrl #(
    .PID_W(PID_W), .FILTER_ID(FILTER_ID)
  ) u_ctrl (
    .busRst(busRst), .busValid(busValid), .busParamId(busParamId), .ctrl(ctrl)
  );

  init_ram_writer_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS_PER_FRAME(WORDS_PER_FRAME),
    .FADDR_W(FADDR_W), .IDX_W(IDX_W), .BUS_W(32)
  ) u_dp (
    .ctrl(ctrl), .busFrameAddr(busFrameAddr), .busIndex(busIndex),
    .busData(busData), .ramAddr(ramAddr), .ramData(ramData),
    .ramWe(ramWe), .ramRst(ramRst)
  );

endmodule

// File: rtl/init_ram_writer_chk.sv
module init_ram_writer_chk #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int WORDS_PER_FRAME = 4,
  parameter int PID_W   = 8,
  parameter logic [PID_W-1:0] FILTER_ID = 8'h5A,
  parameter int FADDR_W = 16,
  parameter int IDX_W   = 8
) (
  input logic               busRst,
  input logic               busValid,
  input logic [PID_W-1:0]   busParamId,
  input logic [FADDR_W-1:0] busFrameAddr,
  input logic [IDX_W-1:0]   busIndex,
  input logic [31:0]        busData,
  input logic [ADDR_W-1:0]  ramAddr,
  input logic [DATA_W-1:0]  ramData,
  input logic               ramWe,
  input logic               ramRst
);

  localparam int IDX_BITS = $clog2(WORDS_PER_FRAME);

  logic unusedChk;
  assign unusedChk = ^{busFrameAddr, busIndex, busData, ramAddr, ramData};

  always_comb begin
    // R2: a write only ever carries the filtered identifier
    p_we_needs_id_r2: assert (!ramWe || (busParamId == FILTER_ID));
    // R1: a write only ever comes from a valid bus word
    p_we_needs_valid_r1: assert (!ramWe || busValid);
    // R7: bus reset blocks writes
    p_rst_blocks_we_r7: assert (!(busRst && ramWe));
    // R6: reset forwarded unchanged
    p_rst_follows_r6: assert (ramRst == busRst);
    // R3: data carries the low bus bits
    p_data_low_r3: assert (ramData == busData[DATA_W-1:0]);
  end

  generate
    if (IDX_BITS > 0) begin : g_idx_chk
      always_comb begin
        // R4: index forms the low address bits
        p_addr_index_r4: assert (ramAddr[IDX_BITS-1:0] == busIndex[IDX_BITS-1:0]);
      end
    end
    if (ADDR_W > IDX_BITS) begin : g_hi_chk
      always_comb begin
        // R5: frame address forms the upper address bits
        p_addr_frame_r5: assert (ramAddr[ADDR_W-1:IDX_BITS] ==
                                 busFrameAddr[ADDR_W-IDX_BITS-1:0]);
      end
    end
  endgenerate

endmodule

bind init_ram_writer init_ram_writer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS_PER_FRAME(WORDS_PER_FRAME),
  .PID_W(PID_W), .FILTER_ID(FILTER_ID), .FADDR_W(FADDR_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/init_ram_writer_test.sv
module init_ram_writer_test;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int WPF    = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FRAMES = DEPTH / WPF;
  localparam logic [7:0] FID = 8'h5A;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        busRst = 1'b1;
  logic        busValid = 1'b0;
  logic [7:0]  busParamId = 8'h00;
  logic [15:0] busFrameAddr = 16'h0;
  logic [7:0]  busIndex = 8'h0;
  logic [31:0] busData = 32'h0;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramData;
  logic ramWe, ramRst;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] mem [DEPTH];

  init_ram_writer uut (
    .busRst(busRst), .busValid(busValid), .busParamId(busParamId),
    .busFrameAddr(busFrameAddr), .busIndex(busIndex), .busData(busData),
    .ramAddr(ramAddr), .ramData(ramData), .ramWe(ramWe), .ramRst(ramRst)
  );

  // Behavioural RAM
  always_ff @(posedge clk) if (ramWe) mem[ramAddr] <= ramData;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a word just after the falling edge; sample 1 ns later (combinational)
  task automatic drive(input logic v, input logic [7:0] id, input logic [15:0] fa,
                       input logic [7:0] ix, input logic [31:0] d);
    @(negedge clk);
    busValid = v; busParamId = id; busFrameAddr = fa; busIndex = ix; busData = d;
    #1;
  endtask

  task automatic t_reset();
    drive(1'b1, FID, 16'h1, 8'h1, 32'h1234_5678);
    check("R7 we low in reset", {31'b0, ramWe}, 32'd0);
    check("R6 rst forwarded", {31'b0, ramRst}, 32'd1);
    busRst = 1'b0; #1;
    check("R6 rst release", {31'b0, ramRst}, 32'd0);
    check("R8 we follows at once", {31'b0, ramWe}, 32'd1);
  endtask

  task automatic t_match();
    drive(1'b1, FID, 16'h0003, 8'h2, 32'hDEAD_BEEF);
    check("R1 we on match", {31'b0, ramWe}, 32'd1);
    check("R3 data low bits", {16'b0, ramData}, 32'h0000_BEEF);
    check("R4 R5 address join", {26'b0, ramAddr}, 32'd14);
    drive(1'b1, FID, 16'hFFC5, 8'hF1, 32'h0000_0001);
    check("R5 high frame bits ignored", {26'b0, ramAddr}, 32'd21);
    check("R4 high index bits ignored", {26'b0, ramAddr[1:0]}, 32'd1);
  endtask

  task automatic t_filter();
    drive(1'b1, 8'h5B, 16'h0003, 8'h2, 32'h0);
    check("R2 no we on other id", {31'b0, ramWe}, 32'd0);
    drive(1'b1, 8'h00, 16'h0003, 8'h2, 32'h0);
    check("R2 no we on id zero", {31'b0, ramWe}, 32'd0);
    drive(1'b0, FID, 16'h0003, 8'h2, 32'h0);
    check("R1 no we without valid", {31'b0, ramWe}, 32'd0);
    @(negedge clk);
    check("R2 memory kept", {16'b0, mem[14]}, 32'h0000_BEEF);
  endtask

  task automatic t_rst_mid();
    drive(1'b1, FID, 16'h0003, 8'h2, 32'h0000_AAAA);
    busRst = 1'b1; #1;
    check("R7 reset forces we low", {31'b0, ramWe}, 32'd0);
    @(negedge clk);
    check("R7 memory kept in reset", {16'b0, mem[14]}, 32'h0000_BEEF);
    busRst = 1'b0;
  endtask

  task automatic t_full_load();
    for (int f = 0; f < FRAMES; f++) begin
      for (int i = 0; i < WPF; i++) begin
        drive(1'b1, FID, f[15:0] + 16'h0100, i[7:0], 32'h7700_0000 | (f * WPF + i + 32'h300));
        check("R9 write address", {26'b0, ramAddr}, f * WPF + i);
      end
      for (int i = 0; i < WPF; i++)
        drive(1'b1, 8'hA5, f[15:0], i[7:0], 32'hFFFF_FFFF);
    end
    drive(1'b0, 8'h00, 16'h0, 8'h0, 32'h0);
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++)
      check("R9 R2 memory content", {16'b0, mem[a]}, 32'h300 + a);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    repeat (2) @(negedge clk);
    #1;
    check("R6 reset state", {31'b0, ramRst}, 32'd1);
    check("R7 reset state we", {31'b0, ramWe}, 32'd0);
    t_reset();
    t_match();
    t_filter();
    t_rst_mid();
    t_full_load();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule